// File: doc/BRIEF.md
# Periodic Gate Event Collision Checker

This block decides whether a candidate periodic gate schedule could ever fire a gate event at exactly the same instant as an already accepted schedule. Each schedule has a cycle time, a base time and a list of entry intervals. All times are 64-bit unsigned nanosecond values. An entry fires a gate event at its base phase plus the sum of the intervals before it, and again every cycle time after that.

Both interval lists are loaded through one write port into two small local memories. A one-cycle start pulse launches the check. First the block takes an early exit when the two cycle times are not whole multiples of each other. Otherwise it reduces each base time modulo its cycle time, using a multi-cycle subtract-and-shift remainder unit, and then compares every occurrence of every entry of both schedules, one pair per clock, up to a bounded horizon. At the end a one-cycle done pulse is raised. The result gives a conflict flag, an input-error flag and the first colliding entry pair.

Top module: `gate_clash_chk`

## Requirements
- R1: A start pulse while idle raises busy from the next cycle. Busy stays high until done. Done is a single-cycle pulse during which busy is low. Start pulses that arrive while busy have no effect.
- R2: A candidate cycle time of zero, or an established cycle time of zero while an established schedule is present, gives cfgError=1 with conflict=0.
- R3: When no established schedule is present (estValid=0) and both cycle times are usable, the result is conflict=0 and cfgError=0.
- R4: When the larger cycle time is not an exact multiple of the smaller one, conflict=1 is reported with estIdx=0 and newIdx=0, and no event is compared.
- R5: The phase of each schedule is its base time modulo its own cycle time, so base times that differ by whole cycles give identical results.
- R6: The comparison horizon is the larger cycle time plus the larger of the two reduced base times. An occurrence equal to the horizon is compared, and one beyond it is not.
- R7: The offset of entry k within its cycle is the sum of the intervals of entries 0 to k-1. Occurrences are phase plus offset, stepped by the cycle time.
- R8: A conflict is reported when an established occurrence equals a candidate occurrence. The pair reported is the first found with the established index as the outer loop and the candidate index as the inner loop.
- R9: conflict, cfgError, estIdx and newIdx keep their values after done until the next accepted start.
- R10: A write with wrSel=1 stores wrData into established entry wrAddr. A write with wrSel=0 stores it into candidate entry wrAddr. Writes while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Interval write enable |
| wrSel | input | 1 | 1 selects the established list, 0 the candidate list |
| wrAddr | input | IDX_W | Entry index to write |
| wrData | input | TIME_W | Interval value in ns |
| estValid | input | 1 | An established schedule is present |
| estCount | input | CNT_W | Established entry count |
| estCycle | input | TIME_W | Established cycle time |
| estBase | input | TIME_W | Established base time |
| newCount | input | CNT_W | Candidate entry count |
| newCycle | input | TIME_W | Candidate cycle time |
| newBase | input | TIME_W | Candidate base time |
| start | input | 1 | Launch pulse |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| conflict | output | 1 | A collision was found |
| cfgError | output | 1 | Zero cycle time was given |
| estIdx | output | IDX_W | Established entry of the first collision |
| newIdx | output | IDX_W | Candidate entry of the first collision |

## Verification
The embedded assertions check the handshake on every cycle: done is a lone pulse that never overlaps busy, and an idle start always raises busy. They also check that results stay frozen outside a run, that an error never comes with a conflict, that every remainder is below its divisor, and that a reported hit lies inside the horizon. Whether the right pair is found can only be shown by the bench scenarios, which compare against a reference model. The same holds for phase reduction with huge base times, the inclusive horizon edge, the early non-multiple exit, and write locking during a run.

// File: rtl/gcc_pkg.sv
package gcc_pkg;

  typedef enum logic [1:0] {
    DIV_RATIO = 2'd0,
    DIV_EST   = 2'd1,
    DIV_NEW   = 2'd2
  } divSel_e;

  typedef struct packed {
    logic    latchCfg;
    logic    clrRes;
    logic    divGo;
    divSel_e divSel;
    logic    divSave;
    divSel_e saveSel;
    logic    initI;
    logic    stepI;
    logic    initJ;
    logic    stepJ;
    logic    initT1;
    logic    stepT1;
    logic    initT2;
    logic    stepT2;
    logic    setErr;
    logic    setHit;
  } ctrlCmd_t;

  typedef struct packed {
    logic cfgBad;
    logic estAbsent;
    logic divDone;
    logic ratioRem;
    logic iEnd;
    logic jEnd;
    logic t1Over;
    logic t2Over;
    logic timeEq;
  } dpStat_t;

endpackage

// File: rtl/gcc_remdiv.sv
module gcc_remdiv #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] rem
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

  logic             running;
  logic [CNT_W-1:0] stepCnt;
  logic [W-1:0]     dvdSh;
  logic [W-1:0]     divQ;
  logic [W-1:0]     remAcc;
  logic             doneQ;
  logic [W:0]       trial;

  assign trial = {remAcc, dvdSh[W-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      stepCnt <= '0;
      dvdSh   <= '0;
      divQ    <= '0;
      remAcc  <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (go) begin
        running <= 1'b1;
        stepCnt <= '0;
        dvdSh   <= dividend;
        divQ    <= divisor;
        remAcc  <= '0;
      end else if (running) begin
        dvdSh <= {dvdSh[W-2:0], 1'b0};
        if (trial >= {1'b0, divQ}) remAcc <= W'(trial - {1'b0, divQ});
        else                       remAcc <= trial[W-1:0];
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt == CNT_W'(W - 1)) begin
          running <= 1'b0;
          doneQ   <= 1'b1;
        end
      end
    end
  end

  assign done = doneQ;
  assign rem  = remAcc;

  p_rem_below_divisor_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (remAcc < divQ));

endmodule

// File: rtl/gate_clash_ctrl.sv
module gate_clash_ctrl
  import gcc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  dpStat_t  stat,
  output ctrlCmd_t cmd,
  output logic     busy,
  output logic     done
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_DIV, S_LOOPI, S_LOOPJ, S_OCC1, S_OCC2, S_DONE
  } state_e;

  state_e  state, stateNx;
  divSel_e phase, phaseNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= DIV_RATIO;
    end else begin
      state <= stateNx;
      phase <= phaseNx;
    end
  end

  always_comb begin
    cmd     = '0;
    cmd.divSel  = DIV_RATIO;
    cmd.saveSel = phase;
    stateNx = state;
    phaseNx = phase;
    unique case (state)
      S_IDLE: if (start) begin
        cmd.latchCfg = 1'b1;
        cmd.clrRes   = 1'b1;
        stateNx      = S_CHECK;
      end
      S_CHECK: begin
        if (stat.cfgBad) begin
          cmd.setErr = 1'b1;
          stateNx    = S_DONE;
        end else if (stat.estAbsent) begin
          stateNx = S_DONE;
        end else begin
          cmd.divGo  = 1'b1;
          cmd.divSel = DIV_RATIO;
          phaseNx    = DIV_RATIO;
          stateNx    = S_DIV;
        end
      end
      S_DIV: if (stat.divDone) begin
        cmd.divSave = 1'b1;
        unique case (phase)
          DIV_RATIO: begin
            if (stat.ratioRem) begin
              cmd.setHit = 1'b1;
              stateNx    = S_DONE;
            end else begin
              cmd.divGo  = 1'b1;
              cmd.divSel = DIV_EST;
              phaseNx    = DIV_EST;
            end
          end
          DIV_EST: begin
            cmd.divGo  = 1'b1;
            cmd.divSel = DIV_NEW;
            phaseNx    = DIV_NEW;
          end
          default: begin
            cmd.initI = 1'b1;
            stateNx   = S_LOOPI;
          end
        endcase
      end
      S_LOOPI: begin
        if (stat.iEnd) stateNx = S_DONE;
        else begin
          cmd.initJ = 1'b1;
          stateNx   = S_LOOPJ;
        end
      end
      S_LOOPJ: begin
        if (stat.jEnd) begin
          cmd.stepI = 1'b1;
          stateNx   = S_LOOPI;
        end else begin
          cmd.initT1 = 1'b1;
          stateNx    = S_OCC1;
        end
      end
      S_OCC1: begin
        if (stat.t1Over) begin
          cmd.stepJ = 1'b1;
          stateNx   = S_LOOPJ;
        end else begin
          cmd.initT2 = 1'b1;
          stateNx    = S_OCC2;
        end
      end
      S_OCC2: begin
        if (stat.t2Over) begin
          cmd.stepT1 = 1'b1;
          stateNx    = S_OCC1;
        end else if (stat.timeEq) begin
          cmd.setHit = 1'b1;
          stateNx    = S_DONE;
        end else begin
          cmd.stepT2 = 1'b1;
        end
      end
      S_DONE:  stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_DONE);
  assign done = (state == S_DONE);

  p_done_not_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_start_raises_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> busy);

endmodule

// File: rtl/gate_clash_dp.sv
module gate_clash_dp
  import gcc_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter int MAX_ENT = 8,
  localparam int IDX_W  = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1,
  localparam int CNT_W  = $clog2(MAX_ENT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlCmd_t          cmd,
  input  logic              busy,
  output dpStat_t           stat,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [TIME_W-1:0] wrData,
  input  logic              estValid,
  input  logic [CNT_W-1:0]  estCount,
  input  logic [TIME_W-1:0] estCycle,
  input  logic [TIME_W-1:0] estBase,
  input  logic [CNT_W-1:0]  newCount,
  input  logic [TIME_W-1:0] newCycle,
  input  logic [TIME_W-1:0] newBase,
  output logic              conflict,
  output logic              cfgError,
  output logic [IDX_W-1:0]  estIdx,
  output logic [IDX_W-1:0]  newIdx
);
  localparam int EXT_W = TIME_W + IDX_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ENT);

  logic [TIME_W-1:0] estMem [MAX_ENT];
  logic [TIME_W-1:0] newMem [MAX_ENT];

  logic              estValidQ;
  logic [CNT_W-1:0]  estCntQ, newCntQ;
  logic [TIME_W-1:0] estCycQ, newCycQ, estBaseQ, newBaseQ;
  logic [TIME_W-1:0] rbtEst, rbtNew;
  logic [CNT_W-1:0]  iIdx, jIdx;
  logic [EXT_W-1:0]  delta1, delta2, t1, t2;

  logic [TIME_W-1:0] maxCyc, minCyc, maxRbt;
  logic [EXT_W-1:0]  horizon;
  logic [TIME_W-1:0] estRd, newRd;
  logic [TIME_W-1:0] divDvd, divDvs, divRem;
  logic              divDone;

  // Interval memories, locked during a run
  always_ff @(posedge clk) begin
    if (wrEn && !busy && ({1'b0, wrAddr} < (IDX_W + 1)'(MAX_ENT))) begin
      if (wrSel) estMem[wrAddr] <= wrData;
      else       newMem[wrAddr] <= wrData;
    end
  end

  assign estRd = (iIdx < CNT_MAX) ? estMem[iIdx[IDX_W-1:0]] : '0;
  assign newRd = (jIdx < CNT_MAX) ? newMem[jIdx[IDX_W-1:0]] : '0;

  assign maxCyc  = (estCycQ >= newCycQ) ? estCycQ : newCycQ;
  assign minCyc  = (estCycQ >= newCycQ) ? newCycQ : estCycQ;
  assign maxRbt  = (rbtEst >= rbtNew) ? rbtEst : rbtNew;
  assign horizon = EXT_W'(maxCyc) + EXT_W'(maxRbt);

  always_comb begin
    unique case (cmd.divSel)
      DIV_RATIO: begin divDvd = maxCyc;   divDvs = minCyc;  end
      DIV_EST:   begin divDvd = estBaseQ; divDvs = estCycQ; end
      default:   begin divDvd = newBaseQ; divDvs = newCycQ; end
    endcase
  end

  gcc_remdiv #(.W(TIME_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .go       (cmd.divGo),
    .dividend (divDvd),
    .divisor  (divDvs),
    .done     (divDone),
    .rem      (divRem)
  );

  // Configuration capture and phase registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      estValidQ <= 1'b0;
      estCntQ   <= '0;
      newCntQ   <= '0;
      estCycQ   <= '0;
      newCycQ   <= '0;
      estBaseQ  <= '0;
      newBaseQ  <= '0;
      rbtEst    <= '0;
      rbtNew    <= '0;
    end else begin
      if (cmd.latchCfg) begin
        estValidQ <= estValid;
        estCntQ   <= (estCount > CNT_MAX) ? CNT_MAX : estCount;
        newCntQ   <= (newCount > CNT_MAX) ? CNT_MAX : newCount;
        estCycQ   <= estCycle;
        newCycQ   <= newCycle;
        estBaseQ  <= estBase;
        newBaseQ  <= newBase;
        rbtEst    <= '0;
        rbtNew    <= '0;
      end
      if (cmd.divSave && cmd.saveSel == DIV_EST) rbtEst <= divRem;
      if (cmd.divSave && cmd.saveSel == DIV_NEW) rbtNew <= divRem;
    end
  end

  // Nested loop counters and occurrence times
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iIdx   <= '0;
      jIdx   <= '0;
      delta1 <= '0;
      delta2 <= '0;
      t1     <= '0;
      t2     <= '0;
    end else begin
      if (cmd.latchCfg || cmd.initI) begin
        iIdx   <= '0;
        delta1 <= '0;
      end else if (cmd.stepI) begin
        iIdx   <= iIdx + 1'b1;
        delta1 <= delta1 + EXT_W'(estRd);
      end
      if (cmd.latchCfg || cmd.initJ) begin
        jIdx   <= '0;
        delta2 <= '0;
      end else if (cmd.stepJ) begin
        jIdx   <= jIdx + 1'b1;
        delta2 <= delta2 + EXT_W'(newRd);
      end
      if (cmd.initT1)      t1 <= EXT_W'(rbtEst) + delta1;
      else if (cmd.stepT1) t1 <= t1 + EXT_W'(estCycQ);
      if (cmd.initT2)      t2 <= EXT_W'(rbtNew) + delta2;
      else if (cmd.stepT2) t2 <= t2 + EXT_W'(newCycQ);
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      conflict <= 1'b0;
      cfgError <= 1'b0;
      estIdx   <= '0;
      newIdx   <= '0;
    end else if (cmd.clrRes) begin
      conflict <= 1'b0;
      cfgError <= 1'b0;
      estIdx   <= '0;
      newIdx   <= '0;
    end else begin
      if (cmd.setErr) cfgError <= 1'b1;
      if (cmd.setHit) begin
        conflict <= 1'b1;
        estIdx   <= iIdx[IDX_W-1:0];
        newIdx   <= jIdx[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    stat.cfgBad    = (newCycQ == '0) || (estValidQ && estCycQ == '0);
    stat.estAbsent = !estValidQ;
    stat.divDone   = divDone;
    stat.ratioRem  = (divRem != '0);
    stat.iEnd      = (iIdx >= estCntQ);
    stat.jEnd      = (jIdx >= newCntQ);
    stat.t1Over    = (t1 > horizon);
    stat.t2Over    = (t2 > horizon);
    stat.timeEq    = (t1 == t2);
  end

  p_hold_results_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmd.clrRes) |=> $stable({conflict, cfgError, estIdx, newIdx}));
  p_err_excludes_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !conflict);
  p_hit_within_horizon_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.setHit && !divDone) |-> (t1 <= horizon && t2 <= horizon));

endmodule

// File: rtl/gate_clash_chk.sv
module gate_clash_chk
  import gcc_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter int MAX_ENT = 8,
  localparam int IDX_W  = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1,
  localparam int CNT_W  = $clog2(MAX_ENT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [TIME_W-1:0] wrData,
  input  logic              estValid,
  input  logic [CNT_W-1:0]  estCount,
  input  logic [TIME_W-1:0] estCycle,
  input  logic [TIME_W-1:0] estBase,
  input  logic [CNT_W-1:0]  newCount,
  input  logic [TIME_W-1:0] newCycle,
  input  logic [TIME_W-1:0] newBase,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              conflict,
  output logic              cfgError,
  output logic [IDX_W-1:0]  estIdx,
  output logic [IDX_W-1:0]  newIdx
);
  ctrlCmd_t cmd;
  dpStat_t  stat;

  gate_clash_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .cmd   (cmd),
    .busy  (busy),
    .done  (done)
  );

  gate_clash_dp #(.TIME_W(TIME_W), .MAX_ENT(MAX_ENT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .busy     (busy),
    .stat     (stat),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .estValid (estValid),
    .estCount (estCount),
    .estCycle (estCycle),
    .estBase  (estBase),
    .newCount (newCount),
    .newCycle (newCycle),
    .newBase  (newBase),
    .conflict (conflict),
    .cfgError (cfgError),
    .estIdx   (estIdx),
    .newIdx   (newIdx)
  );

endmodule

// File: tb/sim_gate_clash_chk.sv
module sim_gate_clash_chk;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 64;
  localparam int ME = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0, wrSel = 1'b0;
  logic [2:0]    wrAddr = '0;
  logic [TW-1:0] wrData = '0;
  logic          estValid = 1'b0;
  logic [3:0]    estCount = '0, newCount = '0;
  logic [TW-1:0] estCycle = '0, estBase = '0, newCycle = '0, newBase = '0;
  logic          start = 1'b0;
  logic          busy, done, conflict, cfgError;
  logic [2:0]    estIdx, newIdx;

  logic [TW-1:0] eList [ME];
  logic [TW-1:0] nList [ME];
  int nTests = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_clash_chk #(.TIME_W(TW), .MAX_ENT(ME)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr),
    .wrData(wrData), .estValid(estValid), .estCount(estCount),
    .estCycle(estCycle), .estBase(estBase), .newCount(newCount),
    .newCycle(newCycle), .newBase(newBase), .start(start), .busy(busy),
    .done(done), .conflict(conflict), .cfgError(cfgError),
    .estIdx(estIdx), .newIdx(newIdx));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic refEval(output bit rc, output bit re, output int ri, output int rj);
    logic [127:0] mx, mn, r1, r2, hz, d1, d2, a, b;
    rc = 0; re = 0; ri = 0; rj = 0;
    if (newCycle == 0 || (estValid && estCycle == 0)) begin re = 1; return; end
    if (!estValid) return;
    mx = (estCycle >= newCycle) ? 128'(estCycle) : 128'(newCycle);
    mn = (estCycle >= newCycle) ? 128'(newCycle) : 128'(estCycle);
    if (mx % mn != 0) begin rc = 1; return; end
    r1 = 128'(estBase % estCycle);
    r2 = 128'(newBase % newCycle);
    hz = mx + ((r1 > r2) ? r1 : r2);
    d1 = 0;
    for (int i = 0; i < int'(estCount); i++) begin
      d2 = 0;
      for (int j = 0; j < int'(newCount); j++) begin
        for (a = r1 + d1; a <= hz; a += 128'(estCycle))
          for (b = r2 + d2; b <= hz; b += 128'(newCycle))
            if (a == b) begin rc = 1; ri = i; rj = j; return; end
        d2 += 128'(nList[j]);
      end
      d1 += 128'(eList[i]);
    end
  endtask

  task automatic writeEntry(input bit sel, input int idx, input logic [63:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrAddr = 3'(idx); wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadLists();
    for (int i = 0; i < int'(estCount); i++) writeEntry(1'b1, i, eList[i]);
    for (int j = 0; j < int'(newCount); j++) writeEntry(1'b0, j, nList[j]);
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(output bit ok);
    int n = 0;
    ok = 1;
    while (done !== 1'b1) begin
      @(negedge clk);
      n++;
      if (n > 20000) begin
        ok = 0;
        nTests++; nFail++;
        $display("FAIL R1 watchdog: done missing actual=0 expected=1");
        return;
      end
    end
  endtask

  task automatic runAndCheck(input string req);
    bit rc, re, ok; int ri, rj;
    refEval(rc, re, ri, rj);
    pulseStart();
    waitDone(ok);
    if (!ok) return;
    check({req, " conflict"}, 64'(conflict), 64'(rc));
    check({req, " cfgError"}, 64'(cfgError), 64'(re));
    if (rc) begin
      check({req, " estIdx"}, 64'(estIdx), 64'(ri));
      check({req, " newIdx"}, 64'(newIdx), 64'(rj));
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    bit ok;
    logic [63:0] unit, kk;
    repeat (3) @(negedge clk);
    // reset state
    check("R1 reset busy", 64'(busy), 0);
    check("R1 reset done", 64'(done), 0);
    check("R9 reset conflict", 64'(conflict), 0);
    rstN = 1'b1;

    // R3: no established schedule
    estValid = 0; estCycle = 100; newCycle = 100; estCount = 1; newCount = 1;
    eList[0] = 10; nList[0] = 10; estBase = 0; newBase = 0;
    loadLists();
    runAndCheck("R3");

    // R2: zero cycle times
    estValid = 1; newCycle = 0; runAndCheck("R2 new zero");
    newCycle = 100; estCycle = 0; runAndCheck("R2 est zero");

    // R4: non-multiple cycle times conflict at once
    estCycle = 100; newCycle = 150; estBase = 1; newBase = 2;
    runAndCheck("R4");
    check("R4 idx", 64'({estIdx, newIdx}), 0);

    // R7: offsets as prefix sums, R8 ordering
    estCycle = 100; newCycle = 100; estBase = 0; newBase = 30;
    estCount = 3; newCount = 1;
    eList[0] = 10; eList[1] = 20; eList[2] = 30; nList[0] = 50;
    loadLists();
    runAndCheck("R7");
    check("R7 est entry 2", 64'(estIdx), 2);

    // R5: huge base times reduce to the same phase
    estBase = 64'd100 * 64'd90000000000000 + 0;
    newBase = 64'd100 * 64'd12345678901234 + 30;
    runAndCheck("R5");
    check("R5 est entry 2", 64'(estIdx), 2);

    // R6: match only beyond the horizon is ignored
    estCycle = 100; newCycle = 100; estBase = 1; newBase = 0;
    estCount = 2; newCount = 2;
    eList[0] = 300; eList[1] = 5; nList[0] = 301; nList[1] = 5;
    loadLists();
    runAndCheck("R6 beyond");
    check("R6 beyond no conflict", 64'(conflict), 0);
    // R6: match exactly at the horizon is found
    estCount = 1; eList[0] = 10; nList[0] = 101;
    loadLists();
    runAndCheck("R6 edge");
    check("R6 edge pair", 64'({conflict, estIdx, newIdx}), 64'({1'b1, 3'd0, 3'd1}));

    // R1: busy after start, start while busy ignored, single done pulse
    estCycle = 100; newCycle = 100; estBase = 7; newBase = 3; estCount = 2; newCount = 2;
    eList[0] = 11; eList[1] = 13; nList[0] = 17; nList[1] = 19;
    loadLists();
    pulseStart();
    check("R1 busy after start", 64'(busy), 1);
    repeat (20) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    // R10: write while busy must be ignored
    wrEn = 1'b1; wrSel = 1'b0; wrAddr = 0; wrData = 64'd1; @(negedge clk); wrEn = 1'b0;
    waitDone(ok);
    if (ok) begin
      begin : first_result
        bit rc, re; int ri, rj;
        refEval(rc, re, ri, rj);
        check("R1 result after ignored start", 64'(conflict), 64'(rc));
      end
      @(negedge clk);
      check("R1 done pulse ends", 64'(done), 0);
      check("R1 no second run", 64'(busy), 0);
      // R9: results hold while idle
      begin : hold_chk
        logic [7:0] snap = {conflict, cfgError, estIdx, newIdx};
        repeat (6) @(negedge clk);
        check("R9 hold", 64'({conflict, cfgError, estIdx, newIdx}), 64'(snap));
      end
    end
    // R10: candidate list still holds the original entry
    runAndCheck("R10 write locked");

    // R10: wrSel steers to the right list; build a collision through writes
    estBase = 0; newBase = 0; estCount = 1; newCount = 2;
    writeEntry(1'b1, 0, 64'd40); eList[0] = 40;
    writeEntry(1'b0, 0, 64'd0);  nList[0] = 0;
    nList[1] = 5; writeEntry(1'b0, 1, 64'd5);
    runAndCheck("R10 steer");

    // Random mix against reference model
    void'($urandom(32'd1234));
    for (int t = 0; t < 60; t++) begin
      unit = 64'd5 * 64'(4 + $urandom % 20);
      kk   = 64'(1 + $urandom % 4);
      if ($urandom % 2) begin estCycle = unit; newCycle = unit * kk; end
      else              begin newCycle = unit; estCycle = unit * kk; end
      if ($urandom % 6 == 0) newCycle = newCycle + 64'd5;
      estBase = {$urandom, $urandom} / 64'd5 * 64'd5;
      newBase = {$urandom, $urandom} / 64'd5 * 64'd5;
      estCount = 4'(1 + $urandom % 4);
      newCount = 4'(1 + $urandom % 4);
      for (int i = 0; i < ME; i++) begin
        eList[i] = 64'd5 * 64'(1 + $urandom % 8);
        nList[i] = 64'd5 * 64'(1 + $urandom % 8);
      end
      estValid = ($urandom % 10 != 0);
      loadLists();
      runAndCheck("R8 random");
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule